// File: doc/BRIEF.md
# Serial Port Interrupt and Control Logic

This block holds the control register of a FIFO-buffered asynchronous serial port and turns the port's status events into four level interrupt requests: transmit FIFO low, receive data available, receive error, and break/overrun. The transmit and receive engines, the FIFO storage, the baud generator and the line sampler sit outside the block. They report to it through single-cycle event strobes and the current transmit FIFO fill level. Software reaches the block through a simple register port with a read strobe, a write strobe and a two-bit register select. The select codes are 0 for control, 1 for status, 2 for line status, and 3 for an unused slot that reads 0.

Status flags follow a protected clearing rule. Software can clear a flag only by writing 0 to it after a read has returned that flag as 1. A stray write of 0 therefore cannot discard an event that software has not yet seen. The block also gates transmission: a write into the transmit FIFO produces a start pulse only while transmission is enabled.

Top module: `sp_irq_ctrl`

## Requirements
- R1: The control register (select 0) stores bits 7 (transmit interrupt enable), 6 (receive interrupt enable), 5 (transmit enable), 4, 3 (receive-error interrupt enable) and 1. Bits 15 to 8, bit 2 and bit 0 always read 0, and writes to them are ignored, so writing 16'hFFFF reads back as 16'h00FA.
- R2: The transmit-low flag (status bit 4) sets when the load strobe fires and the transmit FIFO count is less than or equal to the 4-bit trigger level. With a count above the trigger, the load strobe leaves the flag clear.
- R3: The transmit interrupt is high while the transmit interrupt enable and the transmit-low flag are both 1. It lags them by one clock and drops when either one goes to 0.
- R4: The receive-data interrupt is high while the receive interrupt enable is 1 and either the receive-full flag (status bit 0) or the data-ready flag (status bit 1) is 1.
- R5: The receive-error interrupt is high while the receive-error flag (status bit 2) is 1 and at least one of the receive interrupt enable or the receive-error interrupt enable is 1.
- R6: The break interrupt is high while at least one of the two receive enables is 1 and either the break flag (status bit 3) or the overrun flag is 1. The overrun flag is bit 0 of the line status register (select 2).
- R7: A write of 0 to a flag clears it only if a read of that register has earlier returned the flag as 1. Without such a read, the write of 0 leaves the flag set, and writing 1 never clears a flag.
- R8: A clearing write to the transmit-low flag takes effect only while the FIFO count is above the trigger level. Otherwise the flag stays set.
- R9: When a hardware set event and an accepted clearing write hit the same flag in the same cycle, the flag stays set.
- R10: A transmit FIFO write produces a one-cycle start pulse on the next clock only when transmit enable is 1. With transmit enable at 0, no pulse appears.
- R11: After reset, every register reads 0 and all interrupt and start outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 line status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| tx_fifo_count | input | 5 | Bytes currently in the transmit FIFO |
| tx_trig | input | 4 | Transmit trigger level |
| tx_load | input | 1 | A byte moved from the transmit FIFO into the shifter |
| tx_fifo_wr | input | 1 | Data written into the transmit FIFO |
| rx_full_set | input | 1 | Receive FIFO reached its trigger |
| rx_ready_set | input | 1 | Receive data waiting after line idle |
| rx_err_set | input | 1 | Framing or parity error seen |
| rx_brk_set | input | 1 | Break condition seen |
| rx_ovr_set | input | 1 | Receive overrun |
| tx_start | output | 1 | Start-of-transmission pulse |
| irq_tx | output | 1 | Transmit FIFO low interrupt |
| irq_rx | output | 1 | Receive data interrupt |
| irq_err | output | 1 | Receive error interrupt |
| irq_brk | output | 1 | Break or overrun interrupt |

## Verification
Several properties are checked on every cycle. Each interrupt and the start pulse rises only when its enable was set on the previous cycle. Reserved control bits read 0. A flag that was never read as 1 can never go from 1 to 0. The directed scenarios cover what depends on ordered register traffic: the trigger comparison at its equal boundary, a clearing write that is refused while the FIFO is still low, a set event that overrides a same-cycle clear, and the overrun flag raising the break interrupt from the separate line status register.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;

    localparam int NFLAG = 6;

    localparam int F_RXF = 0;
    localparam int F_RDY = 1;
    localparam int F_ERR = 2;
    localparam int F_BRK = 3;
    localparam int F_TXL = 4;
    localparam int F_OVR = 5;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_LINE = 2'd2;

    localparam int B_TIE  = 7;
    localparam int B_RIE  = 6;
    localparam int B_TE   = 5;
    localparam int B_AUX4 = 4;
    localparam int B_REIE = 3;
    localparam int B_AUX1 = 1;

    typedef struct packed {
        logic tie;
        logic rie;
        logic te;
        logic aux4;
        logic reie;
        logic aux1;
    } ctrl_t;

    function automatic logic [1:0] flag_sel(input int idx);
        return (idx == F_OVR) ? SEL_LINE : SEL_STAT;
    endfunction

    function automatic int flag_bit(input int idx);
        return (idx == F_OVR) ? 0 : idx;
    endfunction

endpackage

// File: rtl/sp_ctrl_reg.sv
module sp_ctrl_reg
    import sp_irq_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.tie  = wdata[B_TIE];
            ctrl_d.rie  = wdata[B_RIE];
            ctrl_d.te   = wdata[B_TE];
            ctrl_d.aux4 = wdata[B_AUX4];
            ctrl_d.reie = wdata[B_REIE];
            ctrl_d.aux1 = wdata[B_AUX1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/sp_flag_cell.sv
module sp_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_req_i,
    input  logic clr_ok_i,
    output logic flag_o,
    output logic armed_o
);

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a read that sees the flag at 1 arms its clear
        if (rd_i && st_q.flag) st_d.armed = 1'b1;
        if (clr_req_i && st_q.armed && clr_ok_i) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        // a new event outranks a clear in the same cycle
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.armed;

endmodule

// File: rtl/sp_irq_gen.sv
module sp_irq_gen
    import sp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tie,
    input  logic             rie,
    input  logic             reie,
    input  logic             te,
    input  logic [NFLAG-1:0] flags,
    input  logic             tx_fifo_wr,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_err,
    output logic             irq_brk,
    output logic             tx_start
);

    typedef struct packed {
        logic tx;
        logic rx;
        logic err;
        logic brk;
        logic start;
    } out_t;

    out_t o_d, o_q;
    logic rx_any_en;

    always_comb begin
        rx_any_en = rie | reie;
        o_d.tx    = tie & flags[F_TXL];
        o_d.rx    = rie & (flags[F_RXF] | flags[F_RDY]);
        o_d.err   = rx_any_en & flags[F_ERR];
        o_d.brk   = rx_any_en & (flags[F_BRK] | flags[F_OVR]);
        o_d.start = te & tx_fifo_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_tx   = o_q.tx;
    assign irq_rx   = o_q.rx;
    assign irq_err  = o_q.err;
    assign irq_brk  = o_q.brk;
    assign tx_start = o_q.start;

endmodule

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl
    import sp_irq_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int TRIG_W    = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]  tx_fifo_count,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic              tx_load,
    input  logic              tx_fifo_wr,
    input  logic              rx_full_set,
    input  logic              rx_ready_set,
    input  logic              rx_err_set,
    input  logic              rx_brk_set,
    input  logic              rx_ovr_set,
    output logic              tx_start,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              irq_brk
);

    ctrl_t            ctrl_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] armed_q;
    logic             tx_low;

    always_comb begin
        tx_low          = (tx_fifo_count <= CNT_W'(tx_trig));
        set_vec         = '0;
        set_vec[F_RXF]  = rx_full_set;
        set_vec[F_RDY]  = rx_ready_set;
        set_vec[F_ERR]  = rx_err_set;
        set_vec[F_BRK]  = rx_brk_set;
        set_vec[F_TXL]  = tx_load && tx_low;
        set_vec[F_OVR]  = rx_ovr_set;
    end

    sp_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr && (reg_sel == SEL_CTRL)),
        .wdata  (reg_wdata),
        .ctrl_o (ctrl_q)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam logic [1:0] FSEL = flag_sel(i);
        localparam int         FBIT = flag_bit(i);
        logic clr_ok;
        if (i == F_TXL) begin : g_gate
            assign clr_ok = !tx_low;
        end else begin : g_free
            assign clr_ok = 1'b1;
        end
        sp_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[i]),
            .rd_i      (reg_rd && (reg_sel == FSEL)),
            .clr_req_i (reg_wr && (reg_sel == FSEL) && !reg_wdata[FBIT]),
            .clr_ok_i  (clr_ok),
            .flag_o    (flag_q[i]),
            .armed_o   (armed_q[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[B_TIE]  = ctrl_q.tie;
                reg_rdata[B_RIE]  = ctrl_q.rie;
                reg_rdata[B_TE]   = ctrl_q.te;
                reg_rdata[B_AUX4] = ctrl_q.aux4;
                reg_rdata[B_REIE] = ctrl_q.reie;
                reg_rdata[B_AUX1] = ctrl_q.aux1;
            end
            SEL_STAT: begin
                for (int k = 0; k < NFLAG; k++)
                    if (flag_sel(k) == SEL_STAT) reg_rdata[flag_bit(k)] = flag_q[k];
            end
            SEL_LINE: reg_rdata[flag_bit(F_OVR)] = flag_q[F_OVR];
            default:  reg_rdata = '0;
        endcase
    end

    sp_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tie        (ctrl_q.tie),
        .rie        (ctrl_q.rie),
        .reie       (ctrl_q.reie),
        .te         (ctrl_q.te),
        .flags      (flag_q),
        .tx_fifo_wr (tx_fifo_wr),
        .irq_tx     (irq_tx),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err),
        .irq_brk    (irq_brk),
        .tx_start   (tx_start)
    );

endmodule

// File: rtl/sp_irq_ctrl_chk.sv
module sp_irq_ctrl_chk
    import sp_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic [1:0]       reg_sel,
    input logic [15:0]      reg_rdata,
    input logic             tx_fifo_wr,
    input logic             tx_start,
    input logic             irq_tx,
    input logic             irq_rx,
    input logic             irq_err,
    input logic             irq_brk,
    input ctrl_t            ctrl_q,
    input logic [NFLAG-1:0] flag_q,
    input logic [NFLAG-1:0] armed_q
);

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_CTRL) |-> (reg_rdata[15:8] == 8'h00 && !reg_rdata[2] && !reg_rdata[0]));

    p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> $past(ctrl_q.tie));

    p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> $past(ctrl_q.rie));

    p_err_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> $past(ctrl_q.rie || ctrl_q.reie));

    p_brk_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_brk |-> $past(ctrl_q.rie || ctrl_q.reie));

    // R7: an unarmed flag never drops
    p_keep_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_q) & ~$past(armed_q) & ~flag_q) == '0));

    p_start_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(tx_fifo_wr && ctrl_q.te));

endmodule

bind sp_irq_ctrl sp_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .tx_fifo_wr (tx_fifo_wr),
    .tx_start   (tx_start),
    .irq_tx     (irq_tx),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err),
    .irq_brk    (irq_brk),
    .ctrl_q     (ctrl_q),
    .flag_q     (flag_q),
    .armed_q    (armed_q)
);

// File: tb/sp_irq_ctrl_tb.sv
module sp_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [4:0]  tx_fifo_count = 5'd0;
    logic [3:0]  tx_trig = 4'd0;
    logic        tx_load = 1'b0, tx_fifo_wr = 1'b0;
    logic        rx_full_set = 1'b0, rx_ready_set = 1'b0, rx_err_set = 1'b0;
    logic        rx_brk_set = 1'b0, rx_ovr_set = 1'b0;
    logic        tx_start, irq_tx, irq_rx, irq_err, irq_brk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_fifo_count(tx_fifo_count), .tx_trig(tx_trig), .tx_load(tx_load),
        .tx_fifo_wr(tx_fifo_wr), .rx_full_set(rx_full_set),
        .rx_ready_set(rx_ready_set), .rx_err_set(rx_err_set),
        .rx_brk_set(rx_brk_set), .rx_ovr_set(rx_ovr_set),
        .tx_start(tx_start), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_err(irq_err), .irq_brk(irq_brk)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = s;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_status(input logic [1:0] s);
        logic [15:0] v;
        rd(s, v);
        wr(s, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R11 ctrl", v, 16'h0000);
        rd(2'd1, v); chk("R11 status", v, 16'h0000);
        rd(2'd2, v); chk("R11 line", v, 16'h0000);
        chk("R11 irqs", {11'd0, irq_tx, irq_rx, irq_err, irq_brk, tx_start}, 16'h0000);
    endtask

    task automatic t_ctrl_r1();
        logic [15:0] v;
        wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R1 all ones", v, 16'h00FA);
        wr(2'd0, 16'h0525); rd(2'd0, v); chk("R1 pattern", v, 16'h0020);
        wr(2'd0, 16'h0000); rd(2'd0, v); chk("R1 zero", v, 16'h0000);
    endtask

    task automatic load(input logic [4:0] cnt, input logic [3:0] trig);
        @(negedge clk);
        tx_fifo_count = cnt; tx_trig = trig; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic t_tx();
        logic [15:0] v;
        wr(2'd0, 16'h0080);
        load(5'd6, 4'd4); settle();
        rd(2'd1, v); chk("R2 above trigger no set", v & 16'h0010, 16'h0000);
        chk("R3 no irq when flag clear", {15'd0, irq_tx}, 16'h0000);
        load(5'd4, 4'd4); settle();
        rd(2'd1, v); chk("R2 equal trigger sets", v & 16'h0010, 16'h0010);
        chk("R3 irq with enable and flag", {15'd0, irq_tx}, 16'h0001);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R8 clear refused while low", v & 16'h0010, 16'h0010);
        @(negedge clk) tx_fifo_count = 5'd9;
        wr(2'd1, 16'h0000); settle();
        rd(2'd1, v); chk("R8 clear after refill", v & 16'h0010, 16'h0000);
        chk("R3 irq drops after clear", {15'd0, irq_tx}, 16'h0000);
        load(5'd1, 4'd2); settle();
        chk("R3 irq again", {15'd0, irq_tx}, 16'h0001);
        wr(2'd0, 16'h0000); settle();
        chk("R3 disable drops irq", {15'd0, irq_tx}, 16'h0000);
        @(negedge clk) tx_fifo_count = 5'd9;
        clear_status(2'd1);
    endtask

    task automatic t_rx_r4();
        logic [15:0] v;
        wr(2'd0, 16'h0040);
        @(negedge clk) rx_ready_set = 1'b1; @(negedge clk) rx_ready_set = 1'b0;
        settle();
        rd(2'd1, v); chk("R4 data-ready bit1", v, 16'h0002);
        chk("R4 irq from data-ready", {15'd0, irq_rx}, 16'h0001);
        wr(2'd1, 16'h0000); settle();
        chk("R4 irq drops", {15'd0, irq_rx}, 16'h0000);
        @(negedge clk) rx_full_set = 1'b1; @(negedge clk) rx_full_set = 1'b0;
        settle();
        chk("R4 irq from full", {15'd0, irq_rx}, 16'h0001);
        wr(2'd0, 16'h0000); settle();
        chk("R4 rie off masks", {15'd0, irq_rx}, 16'h0000);
        clear_status(2'd1);
    endtask

    task automatic t_err_brk();
        logic [15:0] v;
        wr(2'd0, 16'h0008);
        @(negedge clk) rx_err_set = 1'b1; @(negedge clk) rx_err_set = 1'b0;
        settle();
        chk("R5 err irq via error enable", {14'd0, irq_err, irq_rx}, 16'h0002);
        @(negedge clk) rx_brk_set = 1'b1; @(negedge clk) rx_brk_set = 1'b0;
        settle();
        chk("R6 brk irq via error enable", {15'd0, irq_brk}, 16'h0001);
        wr(2'd0, 16'h0000); settle();
        chk("R5 R6 both enables off", {14'd0, irq_err, irq_brk}, 16'h0000);
        clear_status(2'd1);
        wr(2'd0, 16'h0040);
        @(negedge clk) rx_ovr_set = 1'b1; @(negedge clk) rx_ovr_set = 1'b0;
        settle();
        rd(2'd2, v); chk("R6 overrun in line reg", v, 16'h0001);
        chk("R6 brk irq from overrun", {15'd0, irq_brk}, 16'h0001);
        wr(2'd2, 16'h0000); settle();
        chk("R6 brk irq drops", {15'd0, irq_brk}, 16'h0000);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_clear_r7();
        logic [15:0] v;
        @(negedge clk) rx_err_set = 1'b1; @(negedge clk) rx_err_set = 1'b0;
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R7 write without read keeps", v, 16'h0004);
        wr(2'd1, 16'h0004);
        rd(2'd1, v); chk("R7 write of one keeps", v, 16'h0004);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R7 armed clear", v, 16'h0000);
    endtask

    task automatic t_set_wins_r9();
        logic [15:0] v;
        @(negedge clk) rx_brk_set = 1'b1; @(negedge clk) rx_brk_set = 1'b0;
        rd(2'd1, v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0000; rx_brk_set = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; rx_brk_set = 1'b0;
        rd(2'd1, v); chk("R9 set beats clear", v, 16'h0008);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R9 later clear", v, 16'h0000);
    endtask

    task automatic t_start_r10();
        wr(2'd0, 16'h0000);
        @(negedge clk) tx_fifo_wr = 1'b1; @(negedge clk) tx_fifo_wr = 1'b0;
        chk("R10 no start when disabled", {15'd0, tx_start}, 16'h0000);
        wr(2'd0, 16'h0020);
        @(negedge clk) tx_fifo_wr = 1'b1; @(negedge clk) tx_fifo_wr = 1'b0;
        chk("R10 start pulse", {15'd0, tx_start}, 16'h0001);
        @(negedge clk);
        chk("R10 pulse ends", {15'd0, tx_start}, 16'h0000);
        wr(2'd0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_r1();
        t_tx();
        t_rx_r4();
        t_err_brk();
        t_clear_r7();
        t_set_wins_r9();
        t_start_r10();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule